// File: doc/BRIEF.md
# Dual-Issue Fetch and Decode Queue

This front-end stage keeps a twelve-slot instruction queue supplied from an instruction cache that answers every request after a fixed number of cycles. Each request names an 8-byte aligned block, and the block that returns carries two 32-bit instructions. The stage keeps asking for blocks while enough queue space remains, even with several requests still in flight. It does this by reserving two slots for each outstanding block, so a returning block always has room.

The address that follows an accepted request comes from a branch-target-buffer hit, presented against the current request address. With no hit, it is the current address plus eight. A returning block is decoded in the cycle it arrives. Up to two entries, each holding a program counter, an instruction and a branch flag, are written into the queue in program order. The queue head is offered to the issue logic, which pops it only when its scoreboard reports ready. A redirect from the back end discards the queue and every outstanding fetch, and fetching resumes from the new address.

Top module: `dual_fetch_frontend`

## Requirements
- R1: While reset is held and in the first cycle after it, `iss_valid` is low and a request is offered at address `RESET_PC` (default 0x100).
- R2: `req_valid` is high exactly when no redirect is present and DEPTH minus queue occupancy minus twice the number of live outstanding requests is at least two. Queue occupancy never exceeds DEPTH (12).
- R3: After a request is accepted (`req_valid` and `req_ready` both high), the next request address is `btb_target` with bits 2:0 cleared when `btb_hit` was high in the accepting cycle, and the accepted address plus 8 otherwise. Request addresses always have bits 2:0 at zero.
- R4: A live response arrives in the LAT-th cycle (default 3) after its request was accepted. Its bits 31:0 become an entry with the request's address, and its bits 63:32 an entry with that address plus 4. Both are written in the arrival cycle, lower half first.
- R5: An instruction is a branch when bits 31:26 equal 6'h2A, and `iss_branch` reports this. When the lower instruction is a branch and its block was fetched under a BTB hit, the upper instruction is dropped and never issued.
- R6: The queue head is shown on `iss_valid`/`iss_pc`/`iss_instr`/`iss_branch` and leaves only on a cycle with `iss_ready` high. While `iss_ready` is low, the head stays unchanged. Entries leave in the order they were written.
- R7: In a cycle with `redirect_valid` high, no request is offered and any response that arrives is discarded. In the next cycle the queue is empty, and responses to earlier requests never enter it. The next request address is `redirect_pc` with bits 2:0 cleared.
- R8: While a request waits with `req_ready` low and no redirect occurs, `req_valid` stays high and `req_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | Fetch request offered to the cache |
| req_ready | input | 1 | Cache accepts the request this cycle |
| req_addr | output | 32 | 8-byte aligned block address |
| btb_hit | input | 1 | BTB predicts a taken branch in the block at `req_addr` |
| btb_target | input | 32 | Predicted target for that block |
| rsp_valid | input | 1 | Cache returns a block this cycle |
| rsp_data | input | 64 | Returned block, lower instruction in bits 31:0 |
| iss_valid | output | 1 | Queue head available to issue |
| iss_ready | input | 1 | Scoreboard ready; pops the head when `iss_valid` is high |
| iss_pc | output | 32 | Address of the head instruction |
| iss_instr | output | 32 | Head instruction word |
| iss_branch | output | 1 | Head instruction is a branch |
| redirect_valid | input | 1 | Misprediction redirect, flushes the front end |
| redirect_pc | input | 32 | Restart address |

## Verification
The case that matters most is a redirect in the same cycle as a returning block, often together with an issue pop. A flush that loses this race would write stale instructions into a queue that has just been emptied. The bench makes this happen by raising the redirect exactly on cycles when its own cache model is about to return a live block. It counts how often that happens. A cycle-accurate behavioural model built from queues then judges the outcome on every clock: the queue must be empty in the following cycle, and the next request and issued entries must come only from the redirect address.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int unsigned XLEN = 32;
  localparam logic [5:0] BR_OPC_DEFAULT = 6'h2A;

  typedef struct packed {
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] instr;
    logic            br;
  } fe_slot_t;

  function automatic logic [XLEN-1:0] blk_align(input logic [XLEN-1:0] a);
    return {a[XLEN-1:3], 3'b000};
  endfunction
endpackage

// File: rtl/fe_fetch_ctl.sv
module fe_fetch_ctl #(
  parameter int unsigned DEPTH    = 12,
  parameter int unsigned LAT      = 3,
  parameter logic [31:0] RESET_PC = 32'h0000_0100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(DEPTH+1)-1:0]   q_count,
  input  logic                         redirect_valid,
  input  logic [31:0]                  redirect_pc,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [31:0]                  req_addr,
  input  logic                         btb_hit,
  input  logic [31:0]                  btb_target,
  input  logic                         rsp_valid,
  output logic                         rsp_take,
  output logic [31:0]                  rsp_pc,
  output logic                         rsp_taken,
  output logic [$clog2(LAT+1)-1:0]     inflight
);
  import fe_pkg::*;
  localparam int unsigned FW = $clog2(LAT+1);

  logic [31:0]    pc_q;
  logic [LAT-1:0] live_q;
  logic [31:0]    spc_q [LAT];
  logic [LAT-1:0] stk_q;
  logic           fire;
  int             room;

  always_comb begin
    inflight = '0;
    for (int i = 0; i < int'(LAT); i++) inflight = inflight + FW'(live_q[i]);
  end

  always_comb begin
    room      = int'(DEPTH) - int'(q_count) - 2 * int'(inflight);
    req_valid = !redirect_valid && (room >= 2);
  end

  assign req_addr = pc_q;
  assign fire     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)              pc_q <= blk_align(RESET_PC);
    else if (redirect_valid) pc_q <= blk_align(redirect_pc);
    else if (fire)           pc_q <= btb_hit ? blk_align(btb_target) : pc_q + 32'd8;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || redirect_valid) live_q[0] <= 1'b0;
    else                          live_q[0] <= fire;
    spc_q[0] <= pc_q;
    stk_q[0] <= btb_hit;
  end

  generate
    for (genvar s = 1; s < int'(LAT); s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n || redirect_valid) live_q[s] <= 1'b0;
        else                          live_q[s] <= live_q[s-1];
        spc_q[s] <= spc_q[s-1];
        stk_q[s] <= stk_q[s-1];
      end
    end
  endgenerate

  assign rsp_take  = live_q[LAT-1] && rsp_valid && !redirect_valid;
  assign rsp_pc    = spc_q[LAT-1];
  assign rsp_taken = stk_q[LAT-1];
endmodule

// File: rtl/fe_pair_decode.sv
module fe_pair_decode #(
  parameter logic [5:0] BR_OPCODE = fe_pkg::BR_OPC_DEFAULT
) (
  input  logic                      take,
  input  logic [31:0]               pc,
  input  logic                      taken,
  input  logic [63:0]               data,
  output logic [1:0]                wr_en,
  output fe_pkg::fe_slot_t [1:0]    wr_slot
);
  logic [1:0] is_br;

  generate
    for (genvar k = 0; k < 2; k++) begin : g_slot
      assign is_br[k]          = data[32*k+26 +: 6] == BR_OPCODE;
      assign wr_slot[k].pc     = pc + 32'(4 * k);
      assign wr_slot[k].instr  = data[32*k +: 32];
      assign wr_slot[k].br     = is_br[k];
    end
  endgenerate

  assign wr_en[0] = take;
  assign wr_en[1] = take && !(is_br[0] && taken);
endmodule

// File: rtl/fe_inst_queue.sv
module fe_inst_queue #(
  parameter int unsigned DEPTH = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [1:0]                    wr_en,
  input  fe_pkg::fe_slot_t [1:0]        wr_slot,
  output logic                          rd_valid,
  input  logic                          rd_ready,
  output fe_pkg::fe_slot_t              rd_slot,
  output logic [$clog2(DEPTH+1)-1:0]    count
);
  import fe_pkg::*;
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  fe_slot_t        mem [DEPTH];
  logic [PW-1:0]   wptr, rptr;
  logic            pop;
  logic [1:0]      nwr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= int'(DEPTH)) s = s - int'(DEPTH);
    return PW'(s);
  endfunction

  assign rd_valid = count != '0;
  assign rd_slot  = mem[rptr];
  assign pop      = rd_valid && rd_ready;
  assign nwr      = {1'b0, wr_en[0]} + {1'b0, wr_en[1]};

  always_ff @(posedge clk) begin
    if (wr_en[0]) mem[wptr]         <= wr_slot[0];
    if (wr_en[1]) mem[step(wptr,1)] <= wr_slot[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= step(wptr, int'(nwr));
      if (pop) rptr <= step(rptr, 1);
      count <= count + CW'(nwr) - CW'(pop);
    end
  end
endmodule

// File: rtl/dual_fetch_frontend.sv
module dual_fetch_frontend #(
  parameter int unsigned DEPTH     = 12,
  parameter int unsigned LAT       = 3,
  parameter logic [31:0] RESET_PC  = 32'h0000_0100,
  parameter logic [5:0]  BR_OPCODE = 6'h2A
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_addr,
  input  logic        btb_hit,
  input  logic [31:0] btb_target,
  input  logic        rsp_valid,
  input  logic [63:0] rsp_data,
  output logic        iss_valid,
  input  logic        iss_ready,
  output logic [31:0] iss_pc,
  output logic [31:0] iss_instr,
  output logic        iss_branch,
  input  logic        redirect_valid,
  input  logic [31:0] redirect_pc
);
  import fe_pkg::*;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam int unsigned FW = $clog2(LAT+1);

  logic [CW-1:0]    q_count;
  logic [FW-1:0]    inflight;
  logic             rsp_take, rsp_taken;
  logic [31:0]      rsp_pc;
  logic [1:0]       wr_en;
  fe_slot_t [1:0]   wr_slot;
  fe_slot_t         head;

  fe_fetch_ctl #(.DEPTH(DEPTH), .LAT(LAT), .RESET_PC(RESET_PC)) u_fetch (
    .clk(clk), .rst_n(rst_n), .q_count(q_count),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .btb_hit(btb_hit), .btb_target(btb_target),
    .rsp_valid(rsp_valid), .rsp_take(rsp_take), .rsp_pc(rsp_pc),
    .rsp_taken(rsp_taken), .inflight(inflight)
  );

  fe_pair_decode #(.BR_OPCODE(BR_OPCODE)) u_dec (
    .take(rsp_take), .pc(rsp_pc), .taken(rsp_taken), .data(rsp_data),
    .wr_en(wr_en), .wr_slot(wr_slot)
  );

  fe_inst_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(redirect_valid),
    .wr_en(wr_en), .wr_slot(wr_slot),
    .rd_valid(iss_valid), .rd_ready(iss_ready), .rd_slot(head),
    .count(q_count)
  );

  assign iss_pc     = head.pc;
  assign iss_instr  = head.instr;
  assign iss_branch = head.br;
endmodule

// File: rtl/fe_frontend_chk.sv
module fe_frontend_chk #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned LAT   = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic [31:0]                 req_addr,
  input logic                        redirect_valid,
  input logic                        iss_valid,
  input logic                        iss_ready,
  input logic [31:0]                 iss_pc,
  input logic [31:0]                 iss_instr,
  input logic [$clog2(DEPTH+1)-1:0]  q_count,
  input logic [$clog2(LAT+1)-1:0]    inflight
);
  // R2
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) + 2 * int'(inflight) <= int'(DEPTH));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !redirect_valid) |=>
      (redirect_valid || (req_valid && $stable(req_addr))));

  // R6
  iss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !redirect_valid) |=>
      (iss_valid && $stable(iss_pc) && $stable(iss_instr)));

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!iss_valid && inflight == '0));

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[2:0] == 3'b000);
endmodule

bind dual_fetch_frontend fe_frontend_chk #(.DEPTH(DEPTH), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .redirect_valid(redirect_valid),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_pc(iss_pc),
  .iss_instr(iss_instr), .q_count(q_count), .inflight(inflight)
);

// File: tb/dual_fetch_frontend_bench.sv
`timescale 1ns/1ps
module dual_fetch_frontend_bench;
  localparam int DEPTH = 12;
  localparam int LAT   = 3;
  localparam logic [31:0] RST_PC = 32'h0000_0100;
  localparam int NCYC  = 1200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic        btb_hit;
  logic [31:0] btb_target;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        iss_valid, iss_ready, iss_branch;
  logic [31:0] iss_pc, iss_instr;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_fetch_frontend u_dual_fetch_frontend (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .btb_hit(btb_hit), .btb_target(btb_target),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_pc(iss_pc), .iss_instr(iss_instr),
    .iss_branch(iss_branch), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
  );

  function automatic logic [31:0] imem(input logic [31:0] a);
    logic [31:0] w;
    w = a >> 2;
    if (w % 5 == 2) return {6'h2A, w[25:0]};
    return {6'h01, w[25:0]};
  endfunction

  always_comb begin
    btb_hit    = ((req_addr >> 3) % 4) == 1;
    btb_target = ((req_addr + 32'h48) & 32'h0000_03F8) | 32'h3;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench cache and reference model
  int          cq_due[$];
  logic [31:0] cq_addr[$];
  int          lv_due[$];
  logic [31:0] lv_pc[$];
  bit          lv_tk[$];
  logic [31:0] mq_pc[$], mq_in[$];
  bit          mq_br[$];
  logic [31:0] m_pc;

  initial begin
    int cyc;
    int drops, collide, fulls;
    bit prev_redir, exp_req;
    logic [31:0] w0, w1;
    drops = 0; collide = 0; fulls = 0; prev_redir = 1'b0;
    rst_n = 1'b0; req_ready = 1'b0; iss_ready = 1'b0;
    rsp_valid = 1'b0; rsp_data = '0;
    redirect_valid = 1'b0; redirect_pc = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check(!iss_valid, "R1 iss_valid in reset", 64'(iss_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);
    m_pc = RST_PC;
    cyc = 0;
    #1;
    // R1 first cycle after reset
    check(!iss_valid, "R1 iss_valid after reset", 64'(iss_valid), 0);
    check(req_valid, "R1 req_valid after reset", 64'(req_valid), 1);
    check(req_addr == RST_PC, "R1 reset address", 64'(req_addr), 64'(RST_PC));

    for (int n = 0; n < NCYC; n++) begin
      @(negedge clk);
      if (cyc < 60) begin
        iss_ready = 1'b0; req_ready = 1'b1;
      end else begin
        iss_ready = (cyc % 3) != 0;
        req_ready = (cyc % 5) != 1;
      end
      redirect_valid = (cyc == 150) ||
        (cyc >= 200 && cyc < 1100 && cq_due.size() > 0 && cq_due[0] == cyc && (cyc % 9 == 0));
      redirect_pc = 32'h200 + 32'((cyc % 8) * 8) + 32'h4;
      if (cq_due.size() > 0 && cq_due[0] == cyc) begin
        rsp_valid = 1'b1;
        rsp_data  = {imem(cq_addr[0] + 4), imem(cq_addr[0])};
        void'(cq_due.pop_front());
        void'(cq_addr.pop_front());
      end else begin
        rsp_valid = 1'b0;
        rsp_data  = {2{32'hDEAD_0000 ^ 32'(cyc)}};
      end
      #1;
      exp_req = !redirect_valid && (DEPTH - mq_pc.size() - 2 * lv_due.size() >= 2);
      if (mq_pc.size() == DEPTH) fulls++;
      // R2 credit rule
      check(req_valid == exp_req, "R2 req_valid", 64'(req_valid), 64'(exp_req));
      // R3 R8 address sequence and hold
      if (exp_req) check(req_addr == m_pc, "R3 R8 req_addr", 64'(req_addr), 64'(m_pc));
      // R6, R7 after a redirect
      check(iss_valid == (mq_pc.size() > 0), prev_redir ? "R7 iss_valid after flush" : "R6 iss_valid",
            64'(iss_valid), 64'(mq_pc.size() > 0));
      if (mq_pc.size() > 0 && iss_valid) begin
        // R4 R6 order and contents
        check(iss_pc == mq_pc[0], "R4 R6 iss_pc", 64'(iss_pc), 64'(mq_pc[0]));
        check(iss_instr == mq_in[0], "R4 R6 iss_instr", 64'(iss_instr), 64'(mq_in[0]));
        // R5 branch flag
        check(iss_branch == mq_br[0], "R5 iss_branch", 64'(iss_branch), 64'(mq_br[0]));
      end
      if (redirect_valid) begin
        if (lv_due.size() > 0 && lv_due[0] == cyc) collide++;
        mq_pc.delete(); mq_in.delete(); mq_br.delete();
        lv_due.delete(); lv_pc.delete(); lv_tk.delete();
        m_pc = redirect_pc & ~32'h7;
      end else begin
        if (iss_valid && iss_ready && mq_pc.size() > 0) begin
          void'(mq_pc.pop_front()); void'(mq_in.pop_front()); void'(mq_br.pop_front());
        end
        if (lv_due.size() > 0 && lv_due[0] == cyc) begin
          w0 = imem(lv_pc[0]); w1 = imem(lv_pc[0] + 4);
          mq_pc.push_back(lv_pc[0]); mq_in.push_back(w0); mq_br.push_back(w0[31:26] == 6'h2A);
          if (w0[31:26] == 6'h2A && lv_tk[0]) drops++;
          else begin
            mq_pc.push_back(lv_pc[0] + 4); mq_in.push_back(w1); mq_br.push_back(w1[31:26] == 6'h2A);
          end
          void'(lv_due.pop_front()); void'(lv_pc.pop_front()); void'(lv_tk.pop_front());
        end
        if (exp_req && req_ready) begin
          lv_due.push_back(cyc + LAT); lv_pc.push_back(m_pc); lv_tk.push_back(btb_hit);
          cq_due.push_back(cyc + LAT); cq_addr.push_back(m_pc);
          m_pc = btb_hit ? (btb_target & ~32'h7) : m_pc + 32'd8;
        end
      end
      prev_redir = redirect_valid;
      @(posedge clk);
      cyc++;
    end
    // R2 the full-queue stall was reached
    check(fulls > 0, "R2 queue reached full", 64'(fulls), 1);
    // R5 a taken first-slot branch dropped its partner
    check(drops > 0, "R5 second slot dropped", 64'(drops), 1);
    // R7 redirect landed on a live response
    check(collide > 0, "R7 redirect with response", 64'(collide), 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule